// File: doc/BRIEF.md
# Serial Port Pin Multiplexer with General-Purpose I/O

This block sits between the pads of a nine-pin serial port and the serial engines that use them. Eight of the pins can act either as general-purpose I/O or as pins of an SPI-style peripheral. The ninth pin is a receive-only input for a UART. Three 8-bit registers control the pins: a pin-assignment register, a direction register and a port data latch. They are reached through a small word-addressed register bus with two byte lanes.

For each shareable pin the block produces an output value and an output enable. When a pin's assignment bit is clear, the pin takes its value from the data latch. When the bit is set, the pin takes the value the SPI-style engine supplies. In both cases the direction bit decides whether the pad is driven.

The top pin is the UART transmit pin. While the transmitter enable is high, that pin is always driven with the transmit data. Its assignment bit has no effect on it. Pad levels pass through a two-stage synchronizer. The synchronized levels feed the serial engines and the data read path, so a data read reports what is actually on the pins rather than what was written.

Top module: `serialPinMux`

## Requirements
- R1: After reset, all three registers read as zero. Every output enable is low, and `regRdata` is zero.
- R2: When a pin's assignment bit is 0 (and, for pin 7, the transmitter is disabled), `pinOut[i]` equals data-latch bit i and `pinOe[i]` equals direction bit i.
- R3: When the assignment bit is 1 for a pin 0 to 6, `pinOut[i]` equals `periphOut[i]` and `pinOe[i]` equals direction bit i.
- R4: While `uartTxEn` is 1, `pinOe[7]` is 1 and `pinOut[7]` equals `uartTx`, whatever direction bit 7 and assignment bit 7 hold.
- R5: While `uartTxEn` is 0, pin 7 behaves as general-purpose I/O from direction bit 7 and data-latch bit 7. Assignment bit 7 has no effect on it.
- R6: Address 0 holds the direction register in byte lane 0 (bits 7:0) and the assignment register in byte lane 1 (bits 15:8). A write changes only the lanes whose `regByteEn` bit is set.
- R7: A read presents its data on `regRdata` one clock after the cycle in which `regSel`=1 and `regWr`=0 are sampled. The value is held until the next read.
- R8: A read of address 1 returns the synchronized pin levels in bits 7:0 and the synchronized receive level in bit 8. Bits 15:9 read as 0. It does not return the latched data.
- R9: `pinSync` and `rxdSync` follow `pinIn` and `rxdIn` exactly two clock edges later.
- R10: At address 1, only byte lane 0 writes the data latch. Lane 1 write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 1 | Word address (0 = config, 1 = data) |
| regByteEn | input | 2 | Byte-lane write enables |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Registered read data |
| pinIn | input | 8 | Pad input levels of the shareable pins |
| rxdIn | input | 1 | Pad level of the receive pin |
| periphOut | input | 7 | SPI-style engine output values for pins 0..6 |
| uartTxEn | input | 1 | UART transmitter enable |
| uartTx | input | 1 | UART serial output bit |
| pinOut | output | 8 | Pad output values |
| pinOe | output | 8 | Pad output enables |
| pinSync | output | 8 | Synchronized pin levels for the engines |
| rxdSync | output | 1 | Synchronized receive level |

## Verification
Two things can land on pin 7 in the same clock cycle: the transmitter enable rising and a register write that clears direction bit 7. The bench drives both at one falling edge. It then checks that the transmit override still holds the pin driven with the UART bit, and that the pin drops back to the stored direction as soon as the enable falls. A second collision is a data read issued while new pad levels are still inside the synchronizer. The bench times the pad change against the read and expects the pre-update synchronized value, never the written latch.

// File: rtl/serialPinPkg.sv
package serialPinPkg;
  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic wrDir;
    logic wrAsg;
    logic wrDat;
    logic rdCfg;
    logic rdDat;
  } regStrobe_t;
endpackage

// File: rtl/pinRegCtrl.sv
module pinRegCtrl
  import serialPinPkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regByteEn,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(1);

  logic cfgHit;
  logic datHit;
  logic wrAcc;
  logic rdAcc;

  always_comb begin
    cfgHit    = (regAddr == CFG_ADDR);
    datHit    = (regAddr == DAT_ADDR);
    wrAcc     = regSel && regWr;
    rdAcc     = regSel && !regWr;
    stb.wrDir = wrAcc && cfgHit && regByteEn[0];
    stb.wrAsg = wrAcc && cfgHit && regByteEn[1];
    stb.wrDat = wrAcc && datHit && regByteEn[0];
    stb.rdCfg = rdAcc && cfgHit;
    stb.rdDat = rdAcc && datHit;
  end
endmodule

// File: rtl/pinDatapath.sv
module pinDatapath
  import serialPinPkg::*;
#(
  parameter int PIN_N  = 8,
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [2*PIN_N-1:0] wdata,
  output logic [2*PIN_N-1:0] rdata,
  input  logic [PIN_N-1:0]   pinIn,
  input  logic               rxdIn,
  input  logic [PIN_N-2:0]   periphOut,
  input  logic               uartTxEn,
  input  logic               uartTx,
  output logic [PIN_N-1:0]   pinOut,
  output logic [PIN_N-1:0]   pinOe,
  output logic [PIN_N-1:0]   pinSync,
  output logic               rxdSync
);
  localparam int TX_IDX = PIN_N - 1;
  localparam int DW     = 2 * PIN_N;

  logic [PIN_N-1:0] dirReg;
  logic [PIN_N-1:0] asgReg;
  logic [PIN_N-1:0] datReg;
  logic [SYNC_N-1:0][PIN_N:0] syncPipe;

  // Configuration and data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      asgReg <= '0;
      datReg <= '0;
    end else begin
      if (stb.wrDir) dirReg <= wdata[PIN_N-1:0];
      if (stb.wrAsg) asgReg <= wdata[DW-1:PIN_N];
      if (stb.wrDat) datReg <= wdata[PIN_N-1:0];
    end
  end

  // Pad synchronizer, receive pin carried in the top bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= {rxdIn, pinIn};
      for (int k = 1; k < SYNC_N; k++) syncPipe[k] <= syncPipe[k-1];
    end
  end

  assign pinSync = syncPipe[SYNC_N-1][PIN_N-1:0];
  assign rxdSync = syncPipe[SYNC_N-1][PIN_N];

  // Registered read path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdCfg) begin
      rdata <= {asgReg, dirReg};
    end else if (stb.rdDat) begin
      rdata <= {{(PIN_N-1){1'b0}}, rxdSync, pinSync};
    end
  end

  // Per-pin output selection
  for (genvar i = 0; i < PIN_N; i++) begin : gPin
    if (i == TX_IDX) begin : gTx
      always_comb begin
        if (uartTxEn) begin
          pinOut[i] = uartTx;
          pinOe[i]  = 1'b1;
        end else begin
          pinOut[i] = datReg[i];
          pinOe[i]  = dirReg[i];
        end
      end
    end else begin : gShr
      always_comb begin
        pinOut[i] = asgReg[i] ? periphOut[i] : datReg[i];
        pinOe[i]  = dirReg[i];
      end
    end
  end

  // R4
  txForce_chk: assert property (@(posedge clk) disable iff (!rstN)
    uartTxEn |-> (pinOe[TX_IDX] && (pinOut[TX_IDX] == uartTx)));

  // R6
  laneKeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrDir && !stb.wrAsg) |=> $stable(asgReg));

  // R10
  datHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrDat |=> $stable(datReg));

  // R8
  liveRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdDat |=> (rdata[PIN_N-1:0] == $past(pinSync)));

  // R9
  syncFirst_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (syncPipe[0] == $past({rxdIn, pinIn})));

  for (genvar k = 1; k < SYNC_N; k++) begin : gSyncChk
    // R9
    syncStage_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (syncPipe[k] == $past(syncPipe[k-1])));
  end
endmodule

// File: rtl/serialPinMux.sv
module serialPinMux
  import serialPinPkg::*;
#(
  parameter int PIN_N  = 8,
  parameter int SYNC_N = 2,
  parameter int ADDR_W = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [1:0]         regByteEn,
  input  logic [2*PIN_N-1:0] regWdata,
  output logic [2*PIN_N-1:0] regRdata,
  input  logic [PIN_N-1:0]   pinIn,
  input  logic               rxdIn,
  input  logic [PIN_N-2:0]   periphOut,
  input  logic               uartTxEn,
  input  logic               uartTx,
  output logic [PIN_N-1:0]   pinOut,
  output logic [PIN_N-1:0]   pinOe,
  output logic [PIN_N-1:0]   pinSync,
  output logic               rxdSync
);
  regStrobe_t stb;

  pinRegCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regSel    (regSel),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regByteEn (regByteEn),
    .stb       (stb)
  );

  pinDatapath #(.PIN_N(PIN_N), .SYNC_N(SYNC_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (regWdata),
    .rdata     (regRdata),
    .pinIn     (pinIn),
    .rxdIn     (rxdIn),
    .periphOut (periphOut),
    .uartTxEn  (uartTxEn),
    .uartTx    (uartTx),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinSync   (pinSync),
    .rxdSync   (rxdSync)
  );
endmodule

// File: tb/serialPinMux_bench.sv
module serialPinMux_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWr = 1'b0;
  logic [0:0]  regAddr = '0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [7:0]  pinIn = '0;
  logic        rxdIn = 1'b0;
  logic [6:0]  periphOut = '0;
  logic        uartTxEn = 1'b0;
  logic        uartTx = 1'b0;
  logic [7:0]  pinOut;
  logic [7:0]  pinOe;
  logic [7:0]  pinSync;
  logic        rxdSync;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serialPinMux u_serialPinMux (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .pinIn(pinIn), .rxdIn(rxdIn), .periphOut(periphOut), .uartTxEn(uartTxEn),
    .uartTx(uartTx), .pinOut(pinOut), .pinOe(pinOe), .pinSync(pinSync),
    .rxdSync(rxdSync)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [1:0] be, input logic [15:0] data);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = addr; regByteEn = be; regWdata = data;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regByteEn = '0;
  endtask

  task automatic busRead(input logic addr, output logic [15:0] data);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b0; regAddr = addr;
    @(negedge clk);
    data = regRdata;
    regSel = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] rd;
    chk("R1 oe", {8'h0, pinOe}, 16'h0000);
    chk("R1 rdata", regRdata, 16'h0000);
    busRead(1'b0, rd);
    chk("R1 cfg", rd, 16'h0000);
  endtask

  task automatic tGpio();
    busWrite(1'b1, 2'b01, 16'h00A5);
    chk("R2 no drive yet", {8'h0, pinOe}, 16'h0000);
    busWrite(1'b0, 2'b01, 16'h000F);
    chk("R2 oe", {8'h0, pinOe}, 16'h000F);
    chk("R2 out", {8'h0, pinOut}, 16'h00A5);
  endtask

  task automatic tPeriphLanes();
    logic [15:0] rd;
    periphOut = 7'h55;
    busWrite(1'b0, 2'b10, 16'h7FEE);
    busRead(1'b0, rd);
    chk("R6 upper lane only", rd, 16'h7F0F);
    chk("R3 out", {8'h0, pinOut}, 16'h00D5);
    chk("R3 oe", {8'h0, pinOe}, 16'h000F);
    busWrite(1'b0, 2'b01, 16'h00F0);
    busRead(1'b0, rd);
    chk("R6 lower lane only", rd, 16'h7FF0);
    chk("R3 oe follows dir", {8'h0, pinOe}, 16'h00F0);
  endtask

  task automatic tTx();
    busWrite(1'b0, 2'b01, 16'h0000);
    @(negedge clk);
    uartTxEn = 1'b1; uartTx = 1'b1;
    #1;
    chk("R4 oe forced", {15'h0, pinOe[7]}, 16'h0001);
    chk("R4 out high", {15'h0, pinOut[7]}, 16'h0001);
    uartTx = 1'b0;
    #1;
    chk("R4 out low", {15'h0, pinOut[7]}, 16'h0000);
    busWrite(1'b0, 2'b10, 16'hFF00);
    chk("R4 asg ignored", {14'h0, pinOe[7], pinOut[7]}, 16'h0002);
    @(negedge clk);
    uartTxEn = 1'b0;
    #1;
    chk("R5 gpio oe", {15'h0, pinOe[7]}, 16'h0000);
    chk("R5 gpio out", {15'h0, pinOut[7]}, 16'h0001);
    busWrite(1'b0, 2'b01, 16'h0080);
    chk("R5 dir drives", {14'h0, pinOe[7], pinOut[7]}, 16'h0003);
  endtask

  task automatic tCollide();
    @(negedge clk);
    uartTxEn = 1'b1; uartTx = 1'b1;
    regSel = 1'b1; regWr = 1'b1; regAddr = 1'b0; regByteEn = 2'b01; regWdata = 16'h0000;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regByteEn = '0;
    chk("R4 same-cycle dir clear", {14'h0, pinOe[7], pinOut[7]}, 16'h0003);
    uartTxEn = 1'b0;
    #1;
    chk("R5 stored dir after enable drop", {15'h0, pinOe[7]}, 16'h0000);
  endtask

  task automatic tSyncRead();
    logic [15:0] rd;
    @(negedge clk);
    pinIn = 8'h3C; rxdIn = 1'b1;
    @(negedge clk);
    chk("R9 one edge", {7'h0, rxdSync, pinSync}, 16'h0000);
    @(negedge clk);
    chk("R9 two edges", {7'h0, rxdSync, pinSync}, 16'h013C);
    busRead(1'b1, rd);
    chk("R8 live levels", rd, 16'h013C);
    chk("R7 held", regRdata, 16'h013C);
    // read issued in the same cycle the pad value changes
    @(negedge clk);
    pinIn = 8'hC3; regSel = 1'b1; regWr = 1'b0; regAddr = 1'b1;
    @(negedge clk);
    regSel = 1'b0;
    chk("R8 pre-update value", regRdata, 16'h013C);
  endtask

  task automatic tUpperDiscard();
    logic [15:0] rd;
    busWrite(1'b1, 2'b11, 16'hFF66);
    chk("R10 latch lane0", {15'h0, pinOut[7]}, 16'h0000);
    repeat (2) @(negedge clk);
    busRead(1'b1, rd);
    chk("R10 upper discarded", rd, 16'h01C3);
    busRead(1'b0, rd);
    chk("R10 cfg untouched", rd, 16'hFF00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tGpio();
    tPeriphLanes();
    tTx();
    tCollide();
    tSyncRead();
    tUpperDiscard();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule